// File: doc/BRIEF.md
# Voice Codec Serial Data and Control Port

This block is the device side of the serial link of a voice-band codec. It runs on the incoming shift clock and is the frame master: it generates the frame-sync pulse and sets the frame timing. Every 256 clocks a primary frame carries one 16-bit ADC sample out on `dout_o`, most significant bit first. In the same 16 cycles it carries one 16-bit DAC word in on `din_i`. The received DAC word appears on a parallel output together with a one-cycle valid strobe.

The host can ask for a control frame. In full-width mode it holds `fc_i` high. In the 15-plus-flag mode it sets bit 0 of the DAC word. The request is sampled during the last bit of a primary frame. When it is granted, a secondary frame starts 128 clocks after its primary frame. The 16-bit control word then writes an internal 8-bit register, or reads one back on `dout_o` within that same frame, or does nothing.

A state machine sequences the frames through five states:
- `ST_GAP` is the idle time between frames.
- `ST_PSYNC` and `ST_SSYNC` are the one-cycle frame-sync cycles.
- `ST_PXFER` and `ST_SXFER` are the 16-bit transfers.

The transitions are:
- GAP→PSYNC when the period position reaches 254.
- GAP→SSYNC at position 126 when a secondary frame is pending.
- PSYNC→PXFER and SSYNC→SXFER always, after one cycle.
- PXFER→GAP and SXFER→GAP after the 16th bit.

All inputs are sampled at the rising clock edge.

Top module: `codec_serial_port`

## Requirements
- R1: While reset is active, `fs_o`, `dout_o` and `dac_valid_o` are 0 and all registers read 0, which selects full-width mode. The first frame-sync pulse occurs in the first cycle after reset is released.
- R2: `fs_o` is high for exactly one cycle, the cycle just before the first data bit. `dout_o` is 0 in every cycle that is not a transfer bit.
- R3: In a primary frame, `dout_o` carries, MSB first over 16 cycles, the `adc_sample_i` value that was present during the frame-sync cycle.
- R4: The 16 DIN bits of a primary frame form the DAC word, first bit as MSB. It is presented on `dac_sample_o`, with `dac_valid_o` high, in the cycle after the 16th bit.
- R5: When register 1 bit 0 is 0 (full-width mode), `fc_i` during the 16th primary bit requests a secondary frame. DIN bit 0 has no request meaning, and `dac_sample_o` carries all 16 bits.
- R6: When register 1 bit 0 is 1 (15-plus-flag mode), DIN bit 0 of the primary word requests a secondary frame and `fc_i` is ignored. `dac_sample_o` bit 0 is reported as 0.
- R7: A granted secondary frame has its frame-sync 128 cycles after the primary frame-sync. Without a request, the next frame-sync is the primary one, 256 cycles after the last primary frame-sync.
- R8: In a secondary word, bits 15..8 not all zero with bit 13 = 0 write bits 7..0 into the register addressed by bits 12..8. The new value is visible on `cfg_o` in the cycle after the 16th bit.
- R9: A secondary word with bits 15..8 all zero changes no register.
- R10: A secondary word with bit 13 = 1 is a read. `dout_o` is 0 for the first 8 bits, then gives the addressed register MSB first, and no register changes.
- R11: In a secondary frame that is not a read, `dout_o` stays 0 for all 16 bits.
- R12: Addresses at or above the register count (8) are ignored on write and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din_i | input | 1 | Serial DAC / control data from host |
| fc_i | input | 1 | Secondary frame request in full-width mode |
| adc_sample_i | input | 16 | Parallel ADC sample to send |
| fs_o | output | 1 | Frame-sync pulse |
| dout_o | output | 1 | Serial ADC / read-back data to host |
| dac_sample_o | output | 16 | Received DAC sample |
| dac_valid_o | output | 1 | One-cycle strobe for `dac_sample_o` |
| cfg_o | output | 64 | All control registers, register n at bits 8n+7..8n |

## Verification
Every result is timed from the frame-sync cycle:
- Data bit k appears on `dout_o` k+1 cycles after the frame-sync cycle.
- The DAC word and its strobe appear 17 cycles after the frame-sync cycle.
- A register write is visible on `cfg_o` 17 cycles after the secondary frame-sync.

The bench drives and samples only on falling edges. It counts falling edges from each observed frame-sync and compares the count against the expected gap of 1, 111 or 239. A seeded random mix of samples, request settings and control words runs after the directed cases. Each result is compared with a bench model of the register file and of the request rule for the current mode.

// File: rtl/cport_pkg.sv
package cport_pkg;

    typedef enum logic [2:0] {
        ST_GAP   = 3'd0,
        ST_PSYNC = 3'd1,
        ST_PXFER = 3'd2,
        ST_SSYNC = 3'd3,
        ST_SXFER = 3'd4
    } cport_state_e;

endpackage

// File: rtl/cport_fsm.sv
module cport_fsm
    import cport_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int PERIOD  = 256,
    parameter int SEC_OFS = 128,
    parameter int DATA_W  = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_i,
    output cport_state_e state_o,
    output logic         fs_o,
    output logic         pri_load_o,
    output logic         pri_last_o,
    output logic         sec_load_o,
    output logic         sec_mid_o,
    output logic         sec_last_o,
    output logic         xfer_o
);

    localparam int PW = $clog2(PERIOD);
    localparam int BW = $clog2(WORD_W);
    localparam logic [PW-1:0] POS_LAST = PW'(PERIOD - 1);
    localparam logic [PW-1:0] POS_PRE  = PW'(PERIOD - 2);
    localparam logic [PW-1:0] POS_SEC  = PW'(SEC_OFS - 2);
    localparam logic [BW-1:0] BIT_LAST = BW'(WORD_W - 1);
    localparam logic [BW-1:0] BIT_MID  = BW'(DATA_W - 1);

    cport_state_e state_q, state_d;
    logic [PW-1:0] pos_q;
    logic [BW-1:0] bit_q;
    logic          pend_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_GAP;
        else        state_q <= state_d;
    end

    // period position, bit index and pending request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= POS_PRE;
            bit_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            pos_q <= (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
            if (state_q == ST_PXFER || state_q == ST_SXFER) bit_q <= bit_q + 1'b1;
            else                                            bit_q <= '0;
            if (state_q == ST_PXFER && bit_q == BIT_LAST) pend_q <= req_i;
            else if (state_q == ST_SSYNC)                 pend_q <= 1'b0;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_GAP: begin
                if (pos_q == POS_PRE)                state_d = ST_PSYNC;
                else if (pend_q && pos_q == POS_SEC) state_d = ST_SSYNC;
            end
            ST_PSYNC: state_d = ST_PXFER;
            ST_SSYNC: state_d = ST_SXFER;
            ST_PXFER: if (bit_q == BIT_LAST) state_d = ST_GAP;
            ST_SXFER: if (bit_q == BIT_LAST) state_d = ST_GAP;
            default:  state_d = ST_GAP;
        endcase
    end

    // outputs
    always_comb begin
        fs_o       = 1'b0;
        pri_load_o = 1'b0;
        pri_last_o = 1'b0;
        sec_load_o = 1'b0;
        sec_mid_o  = 1'b0;
        sec_last_o = 1'b0;
        xfer_o     = 1'b0;
        unique case (state_q)
            ST_GAP: ;
            ST_PSYNC: begin
                fs_o       = 1'b1;
                pri_load_o = 1'b1;
            end
            ST_SSYNC: begin
                fs_o       = 1'b1;
                sec_load_o = 1'b1;
            end
            ST_PXFER: begin
                xfer_o     = 1'b1;
                pri_last_o = (bit_q == BIT_LAST);
            end
            ST_SXFER: begin
                xfer_o     = 1'b1;
                sec_mid_o  = (bit_q == BIT_MID);
                sec_last_o = (bit_q == BIT_LAST);
            end
            default: ;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/cport_shifter.sv
module cport_shifter #(
    parameter int WORD_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] load_val_i,
    input  logic              mid_load_i,
    input  logic [DATA_W-1:0] mid_val_i,
    input  logic              shift_i,
    input  logic              din_i,
    output logic              tx_bit_o,
    output logic [WORD_W-1:0] word_o
);

    logic [WORD_W-1:0] tx_q;
    logic [WORD_W-1:0] rx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            if (load_i)          tx_q <= load_val_i;
            else if (mid_load_i) tx_q <= {mid_val_i, {(WORD_W-DATA_W){1'b0}}};
            else if (shift_i)    tx_q <= {tx_q[WORD_W-2:0], 1'b0};
            if (shift_i)         rx_q <= {rx_q[WORD_W-2:0], din_i};
        end
    end

    assign tx_bit_o = tx_q[WORD_W-1];
    // word including the bit on DIN in this cycle
    assign word_o   = {rx_q[WORD_W-2:0], din_i};

endmodule

// File: rtl/cport_regfile.sv
module cport_regfile #(
    parameter int NREGS  = 8,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_i,
    input  logic [ADDR_W-1:0]       waddr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    input  logic [ADDR_W-1:0]       raddr_i,
    output logic [DATA_W-1:0]       rdata_o,
    output logic [NREGS*DATA_W-1:0] cfg_o
);

    localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        logic [DATA_W-1:0] r_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                                     r_q <= '0;
            else if (we_i && waddr_i == ADDR_W'(g)) r_q <= wdata_i;
        end
        assign cfg_o[g*DATA_W +: DATA_W] = r_q;
    end

    logic              in_range;
    logic [IDX_W-1:0]  ridx;

    assign in_range = (int'(raddr_i) < NREGS);
    assign ridx     = in_range ? IDX_W'(raddr_i) : '0;
    assign rdata_o  = in_range ? cfg_o[int'(ridx)*DATA_W +: DATA_W] : '0;

endmodule

// File: rtl/codec_serial_port.sv
module codec_serial_port
    import cport_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int PERIOD  = 256,
    parameter int SEC_OFS = 128,
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 5,
    parameter int NREGS   = 8,
    parameter int FMT_REG = 1,
    parameter int FMT_BIT = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    din_i,
    input  logic                    fc_i,
    input  logic [WORD_W-1:0]       adc_sample_i,
    output logic                    fs_o,
    output logic                    dout_o,
    output logic [WORD_W-1:0]       dac_sample_o,
    output logic                    dac_valid_o,
    output logic [NREGS*DATA_W-1:0] cfg_o
);

    localparam int RD_BIT = DATA_W + ADDR_W;
    localparam int FMT_IX = FMT_REG * DATA_W + FMT_BIT;

    cport_state_e      state_w;
    logic              pri_load_w, pri_last_w, sec_load_w, sec_mid_w, sec_last_w, xfer_w;
    logic              tx_bit_w, mode_flag_w, req_w, mid_load_w, we_w;
    logic [WORD_W-1:0] word_w, load_val_w;
    logic [DATA_W-1:0] rdata_w;

    assign mode_flag_w = cfg_o[FMT_IX];
    assign req_w       = mode_flag_w ? din_i : fc_i;

    cport_fsm #(
        .WORD_W(WORD_W), .PERIOD(PERIOD), .SEC_OFS(SEC_OFS), .DATA_W(DATA_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_i(req_w), .state_o(state_w), .fs_o(fs_o),
        .pri_load_o(pri_load_w), .pri_last_o(pri_last_w), .sec_load_o(sec_load_w),
        .sec_mid_o(sec_mid_w), .sec_last_o(sec_last_w), .xfer_o(xfer_w)
    );

    assign load_val_w = pri_load_w ? adc_sample_i : '0;
    // after the command byte: word_w[DATA_W-1:0] holds bits 15..8
    assign mid_load_w = sec_mid_w & word_w[ADDR_W];

    cport_shifter #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .load_i(pri_load_w | sec_load_w), .load_val_i(load_val_w),
        .mid_load_i(mid_load_w), .mid_val_i(rdata_w),
        .shift_i(xfer_w), .din_i(din_i),
        .tx_bit_o(tx_bit_w), .word_o(word_w)
    );

    assign we_w = sec_last_w & ~word_w[RD_BIT] & (|word_w[WORD_W-1:DATA_W]);

    cport_regfile #(.NREGS(NREGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(we_w),
        .waddr_i(word_w[RD_BIT-1:DATA_W]), .wdata_i(word_w[DATA_W-1:0]),
        .raddr_i(word_w[ADDR_W-1:0]), .rdata_o(rdata_w), .cfg_o(cfg_o)
    );

    assign dout_o = xfer_w & tx_bit_w;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_sample_o <= '0;
            dac_valid_o  <= 1'b0;
        end else begin
            dac_valid_o <= pri_last_w;
            if (pri_last_w)
                dac_sample_o <= mode_flag_w ? {word_w[WORD_W-1:1], 1'b0} : word_w;
        end
    end

endmodule

// File: rtl/codec_serial_port_chk.sv
module codec_serial_port_chk #(
    parameter int PERIOD  = 256,
    parameter int SEC_OFS = 128,
    parameter int CFG_W   = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fs,
    input logic             dout,
    input logic             dac_valid,
    input logic             xfer,
    input logic             sec_last,
    input logic [CFG_W-1:0] cfg
);

    int   since_q;
    logic seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= 0;
            seen_q  <= 1'b0;
        end else if (fs) begin
            since_q <= 1;
            seen_q  <= 1'b1;
        end else if (since_q <= PERIOD) begin
            since_q <= since_q + 1;
        end
    end

    // R2
    fs_single_chk: assert property (@(posedge clk) disable iff (!rst_n) fs |=> !fs);
    // R2
    fs_not_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n) fs |-> !xfer);
    // R11
    dout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !xfer |-> !dout);
    // R7
    fs_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fs && seen_q) |-> (since_q == SEC_OFS || since_q == PERIOD));
    // R4
    valid_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |-> ($past(xfer) && !xfer));
    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) dac_valid |=> !dac_valid);
    // R8
    cfg_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg) |-> $past(sec_last));

endmodule

bind codec_serial_port codec_serial_port_chk #(
    .PERIOD(PERIOD), .SEC_OFS(SEC_OFS), .CFG_W(NREGS*DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .fs(fs_o), .dout(dout_o), .dac_valid(dac_valid_o),
    .xfer(xfer_w), .sec_last(sec_last_w), .cfg(cfg_o)
);

// File: tb/codec_serial_port_bench.sv
`timescale 1ns/1ps
module codec_serial_port_bench;

    localparam int NREGS    = 8;
    localparam int GAP_PP   = 239;
    localparam int GAP_PS   = 111;
    localparam int GAP_SP   = 111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        din_i = 1'b0;
    logic        fc_i = 1'b0;
    logic [15:0] adc_sample_i = '0;
    logic        fs_o, dout_o, dac_valid_o;
    logic [15:0] dac_sample_o;
    logic [63:0] cfg_o;

    codec_serial_port u_codec_serial_port (
        .clk(clk), .rst_n(rst_n), .din_i(din_i), .fc_i(fc_i),
        .adc_sample_i(adc_sample_i), .fs_o(fs_o), .dout_o(dout_o),
        .dac_sample_o(dac_sample_o), .dac_valid_o(dac_valid_o), .cfg_o(cfg_o)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int next_gap;
    logic [7:0] mdl [NREGS];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    function automatic logic [63:0] packed_mdl();
        logic [63:0] v;
        for (int i = 0; i < NREGS; i++) v[i*8 +: 8] = mdl[i];
        return v;
    endfunction

    function automatic logic [15:0] exp_dac(input logic [15:0] w, input bit flag_mode);
        return flag_mode ? {w[15:1], 1'b0} : w;
    endfunction

    function automatic logic [15:0] exp_sec_dout(input logic [15:0] cmd);
        if (!cmd[13]) return 16'h0000;
        if (int'(cmd[12:8]) >= NREGS) return 16'h0000;
        return {8'h00, mdl[cmd[12:8]]};
    endfunction

    task automatic wait_fs(input int exp_gap, input string req);
        int n = 0;
        bit idle_ok = 1'b1;
        do begin
            @(negedge clk);
            n++;
            if (fs_o !== 1'b1 && dout_o !== 1'b0) idle_ok = 1'b0;
        end while (fs_o !== 1'b1 && n < 400);
        chk(n == exp_gap, req, n, exp_gap);
        chk(idle_ok, "R2 idle dout", {63'd0, ~idle_ok}, 0);
    endtask

    task automatic xfer16(input logic [15:0] w, input logic fc, output logic [15:0] got);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            din_i = w[15-k];
            fc_i  = fc;
            got[15-k] = dout_o;
            if (k == 0) chk(fs_o == 1'b0, "R2 fs width", fs_o, 0);
        end
        @(negedge clk);
        din_i = 1'b0;
        fc_i  = 1'b0;
    endtask

    task automatic run_period(input logic [15:0] adc, input logic [15:0] dac,
                              input logic fc, input logic [15:0] cmd);
        logic [15:0] got, exp_d;
        bit flag_mode, req, is_wr;
        string tag;
        flag_mode = mdl[1][0];
        req = flag_mode ? dac[0] : fc;
        wait_fs(next_gap, "R7 primary gap");
        adc_sample_i = adc;
        xfer16(dac, fc, got);
        chk(got == adc, "R3 adc out", got, adc);
        chk(dac_valid_o == 1'b1, "R4 valid", dac_valid_o, 1);
        chk(dac_sample_o == exp_dac(dac, flag_mode), flag_mode ? "R6 dac" : "R5 dac",
            dac_sample_o, exp_dac(dac, flag_mode));
        if (req) begin
            wait_fs(GAP_PS, flag_mode ? "R6 R7 sec gap" : "R5 R7 sec gap");
            exp_d = exp_sec_dout(cmd);
            xfer16(cmd, 1'b0, got);
            if (cmd[13]) tag = (int'(cmd[12:8]) >= NREGS) ? "R12 read" : "R10 read";
            else         tag = "R11 dout";
            chk(got == exp_d, tag, got, exp_d);
            is_wr = !cmd[13] && (cmd[15:8] != 8'h00);
            if (is_wr && int'(cmd[12:8]) < NREGS) mdl[cmd[12:8]] = cmd[7:0];
            if (cmd[15:8] == 8'h00)                    tag = "R9 nop";
            else if (is_wr && int'(cmd[12:8]) >= NREGS) tag = "R12 write";
            else if (is_wr)                             tag = "R8 write";
            else                                        tag = "R10 no change";
            chk(cfg_o == packed_mdl(), tag, cfg_o, packed_mdl());
            next_gap = GAP_SP;
        end else begin
            next_gap = GAP_PP;
        end
    endtask

    initial begin
        #(5.0 * 190000);
        chk(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        logic [15:0] r_adc, r_dac, r_cmd;
        logic        r_fc;
        void'($urandom(32'd2024));
        for (int i = 0; i < NREGS; i++) mdl[i] = 8'h00;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(fs_o == 1'b0 && dout_o == 1'b0 && dac_valid_o == 1'b0, "R1 outputs",
            {fs_o, dout_o, dac_valid_o}, 0);
        chk(cfg_o == 64'd0, "R1 regs", cfg_o, 0);
        rst_n = 1'b1;
        next_gap = 1;   // R1 first frame-sync right after reset

        // R5: full-width mode, DIN bit 0 does not request
        run_period(16'hA5C3, 16'h1235, 1'b0, 16'h0000);
        // R5 + R8: request via fc, write reg 3
        run_period(16'h0F0F, 16'h8001, 1'b1, 16'h035A);
        // R10: read reg 3
        run_period(16'hFFFF, 16'h4444, 1'b1, 16'h2300);
        // R9: nop with data bits set
        run_period(16'h0001, 16'h7FFE, 1'b1, 16'h00FF);
        // R12: out-of-range write then read
        run_period(16'h8000, 16'h1111, 1'b1, 16'h14AA);
        run_period(16'h1234, 16'h2222, 1'b1, 16'h3400);
        // switch to 15-plus-flag mode
        run_period(16'h5555, 16'h3333, 1'b1, 16'h0101);
        // R6: fc ignored, flag 0
        run_period(16'hAAAA, 16'h9998, 1'b1, 16'h0000);
        // R6: flag 1 requests, read reg 1
        run_period(16'hC001, 16'h6667, 1'b0, 16'h2100);

        for (int n = 0; n < 50; n++) begin
            r_adc = 16'($urandom);
            r_dac = 16'($urandom);
            r_fc  = 1'($urandom);
            r_cmd = 16'($urandom);
            if (($urandom % 4) == 0) r_cmd[15:8] = 8'h00;
            run_period(r_adc, r_dac, r_fc, r_cmd);
        end
        summary();
    end

endmodule